// File: doc/BRIEF.md
# APM Command and Status Byte Port

This block gives software two byte-wide registers in the I/O space, used for handing power management requests to a system management handler. The pair occupies two neighbouring port addresses: the even one holds a command byte, the odd one a status byte. Both hold whatever was last written to them and return it on a read. The status byte is a plain mailbox with no side effects.

A write to the command byte is also an event. The `USE_SMI` parameter fixes at elaboration what that event does. When it is set, every command write raises a system management interrupt request, whatever the data. When it is clear, the block decodes two command codes itself and switches the ACPI SCI enable bit. This lets a system without a management handler still move between legacy and ACPI operation.

Top module: `apm_smi_port`

## Requirements
- R1: While `rstN` is low, and after it rises, the command byte, the status byte and `sciEn` are 0 and `smiReq` is low.
- R2: The pair is decoded when `ioAddr[15:1]` equals bits 15:1 of `BASE_ADDR` (default 0x00B2). Address bit 0 low selects the command byte and bit 0 high selects the status byte. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R3: A read of either register returns exactly the last byte written to it. `ioRdData` is combinational and is 0x00 whenever `ioRd` is low.
- R4: With `USE_SMI`=1, each command-byte write drives `smiReq` high for exactly one cycle, in the cycle after the write strobe, for any data value. Writes on consecutive cycles give one high cycle each.
- R5: A status-byte write only stores the value. It raises no `smiReq` and leaves `sciEn` unchanged.
- R6: With `USE_SMI`=0, writing 0xF1 to the command byte sets `sciEn` and writing 0xF0 clears it, from the cycle after the strobe. Any other command value leaves `sciEn` unchanged, and `smiReq` never goes high.
- R7: A read in the same cycle as a write to the same register returns the value held before that write.
- R8: With `USE_SMI`=1, command writes of 0xF0 or 0xF1 leave `sciEn` unchanged at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 16 | I/O port address |
| ioWrData | input | 8 | Write data byte |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioRd | input | 1 | Read strobe |
| ioRdData | output | 8 | Read data, valid in the strobe cycle |
| smiReq | output | 1 | One-cycle management interrupt request |
| sciEn | output | 1 | ACPI SCI enable bit |

## Verification
The bench drives one instance of each build option from the same bus stimulus, so every write shows both the interrupt response and the decoded enable response side by side. Command writes cover the two special codes and neutral codes such as 0x00, 0xFF and 0x3C. These separate a decoder that matches exact bytes from one that looks at only some bits. Status writes of the special codes show that the event logic watches the address and not the data. Near-miss addresses (0xB0, 0xB4, 0x01B2), a write with a read in the same cycle, back-to-back command writes and a reset in mid-run separate a correct decode, read ordering and pulse shape from close but wrong versions.

// File: rtl/apm_pkg.sv
package apm_pkg;

  // Strobes handed from the decode/control side to the datapath
  typedef struct packed {
    logic ctrlSel;   // address hits the command byte
    logic statSel;   // address hits the status byte
    logic ctrlWr;    // command byte write this cycle
    logic statWr;    // status byte write this cycle
    logic rdEn;      // read strobe qualified by a hit
    logic smiFire;   // request a management interrupt
    logic sciSet;    // decoded enable command
    logic sciClr;    // decoded disable command
  } apmStrobes_t;

endpackage

// File: rtl/apm_ctrl.sv
module apm_ctrl
  import apm_pkg::*;
#(
  parameter int                  ADDR_W    = 16,
  parameter int                  DATA_W    = 8,
  parameter logic [ADDR_W-1:0]   BASE_ADDR = 'h00B2,
  parameter bit                  USE_SMI   = 1'b1,
  parameter logic [DATA_W-1:0]   CMD_ON    = 'hF1,
  parameter logic [DATA_W-1:0]   CMD_OFF   = 'hF0
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  output apmStrobes_t       strb
);

  localparam int PAIR_MSB = ADDR_W - 1;

  logic pairHit;
  logic ctrlSel;
  logic statSel;
  logic ctrlWr;
  logic smiFire;
  logic sciSet;
  logic sciClr;

  assign pairHit = (ioAddr[PAIR_MSB:1] == BASE_ADDR[PAIR_MSB:1]);
  assign ctrlSel = pairHit & ~ioAddr[0];
  assign statSel = pairHit &  ioAddr[0];
  assign ctrlWr  = ioWr & ctrlSel;

  generate
    if (USE_SMI) begin : g_smi
      assign smiFire = ctrlWr;
      assign sciSet  = 1'b0;
      assign sciClr  = 1'b0;
    end else begin : g_decode
      assign smiFire = 1'b0;
      assign sciSet  = ctrlWr & (ioWrData == CMD_ON);
      assign sciClr  = ctrlWr & (ioWrData == CMD_OFF);
    end
  endgenerate

  always_comb begin
    strb.ctrlSel = ctrlSel;
    strb.statSel = statSel;
    strb.ctrlWr  = ctrlWr;
    strb.statWr  = ioWr & statSel;
    strb.rdEn    = ioRd & pairHit;
    strb.smiFire = smiFire;
    strb.sciSet  = sciSet;
    strb.sciClr  = sciClr;
  end

endmodule

// File: rtl/apm_datapath.sv
module apm_datapath
  import apm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  apmStrobes_t       strb,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic              smiReq,
  output logic              sciEn
);

  logic [DATA_W-1:0] ctrlByte;
  logic [DATA_W-1:0] statByte;
  logic              smiQ;
  logic              sciQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlByte <= '0;
      statByte <= '0;
      smiQ     <= 1'b0;
      sciQ     <= 1'b0;
    end else begin
      if (strb.ctrlWr) ctrlByte <= ioWrData;
      if (strb.statWr) statByte <= ioWrData;
      smiQ <= strb.smiFire;
      if (strb.sciSet)      sciQ <= 1'b1;
      else if (strb.sciClr) sciQ <= 1'b0;
    end
  end

  // Combinational read: a same-cycle write lands at the edge, so the old value shows
  always_comb begin
    ioRdData = '0;
    if (strb.rdEn) begin
      if (strb.ctrlSel)      ioRdData = ctrlByte;
      else if (strb.statSel) ioRdData = statByte;
    end
  end

  assign smiReq = smiQ;
  assign sciEn  = sciQ;

endmodule

// File: rtl/apm_smi_port.sv
module apm_smi_port
  import apm_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h00B2,
  parameter bit                USE_SMI   = 1'b1,
  parameter logic [DATA_W-1:0] CMD_ON    = 'hF1,
  parameter logic [DATA_W-1:0] CMD_OFF   = 'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  output logic [DATA_W-1:0] ioRdData,
  output logic              smiReq,
  output logic              sciEn
);

  apmStrobes_t strb;

  apm_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
    .USE_SMI(USE_SMI), .CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF)
  ) u_ctrl (
    .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr), .ioRd(ioRd), .strb(strb)
  );

  apm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .smiReq(smiReq), .sciEn(sciEn)
  );

endmodule

// File: rtl/apm_smi_port_chk.sv
module apm_smi_port_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h00B2,
  parameter bit                USE_SMI   = 1'b1,
  parameter logic [DATA_W-1:0] CMD_ON    = 'hF1,
  parameter logic [DATA_W-1:0] CMD_OFF   = 'hF0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [DATA_W-1:0] ioWrData,
  input logic              ioWr,
  input logic              ioRd,
  input logic [DATA_W-1:0] ioRdData,
  input logic              smiReq,
  input logic              sciEn
);

  logic cmdWrite;
  logic statWrite;
  assign cmdWrite  = ioWr && (ioAddr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]) && !ioAddr[0];
  assign statWrite = ioWr && (ioAddr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]) &&  ioAddr[0];

  // R4: a command write in SMI mode fires the request next cycle
  a_r4_smi_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (USE_SMI && cmdWrite) |=> smiReq);

  // R4 R5: no request without a command write in the cycle before
  a_r4_smi_only_after_write: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWrite |=> !smiReq);

  // R6: decode mode never requests an interrupt
  a_r6_no_smi_in_decode: assert property (@(posedge clk) disable iff (!rstN)
    !USE_SMI |-> !smiReq);

  // R6: enable and disable codes take effect next cycle
  a_r6_sci_on: assert property (@(posedge clk) disable iff (!rstN)
    (!USE_SMI && cmdWrite && ioWrData == CMD_ON) |=> sciEn);
  a_r6_sci_off: assert property (@(posedge clk) disable iff (!rstN)
    (!USE_SMI && cmdWrite && ioWrData == CMD_OFF) |=> !sciEn);

  // R5 R6: the enable bit moves only on a command write
  a_r5_sci_stable: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWrite |=> $stable(sciEn));

  // R8: SMI mode never sets the enable bit
  a_r8_sci_idle_smi: assert property (@(posedge clk) disable iff (!rstN)
    USE_SMI |-> !sciEn);

  // R3: idle read bus reads zero
  a_r3_rd_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> (ioRdData == '0));

  // R5: a status write gives no request
  a_r5_status_quiet: assert property (@(posedge clk) disable iff (!rstN)
    statWrite |=> !smiReq);

endmodule

bind apm_smi_port apm_smi_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
  .USE_SMI(USE_SMI), .CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
  .ioRd(ioRd), .ioRdData(ioRdData), .smiReq(smiReq), .sciEn(sciEn)
);

// File: tb/apm_smi_port_bench.sv
module apm_smi_port_bench;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
    logic        wr;
    logic        rd;
    logic [7:0]  expRd;
    logic        expSmi;  // SMI-mode instance, cycle after the strobe
    logic        expSci;  // decode-mode instance, cycle after the strobe
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{16'h00B2, 8'h55, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},  // R4 command write
    '{16'h00B2, 8'h00, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0},  // R3 readback
    '{16'h00B3, 8'hA5, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},  // R5 status write
    '{16'h00B3, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},  // R3 status readback
    '{16'h00B2, 8'hF1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1},  // R6 enable, R8
    '{16'h00B2, 8'h3C, 1'b1, 1'b1, 8'hF1, 1'b1, 1'b1},  // R7 old value, R6 neutral
    '{16'h00B2, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1},  // R3
    '{16'h00B3, 8'hF0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},  // R5 code on status
    '{16'h00B2, 8'hF0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},  // R6 disable
    '{16'h00B0, 8'hF1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},  // R2 miss
    '{16'h01B2, 8'hF1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},  // R2 upper bits miss
    '{16'h00B2, 8'h00, 1'b0, 1'b1, 8'hF0, 1'b0, 1'b0},  // R2 command unchanged
    '{16'h00B4, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // R2 read miss
    '{16'h00B2, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},  // R4 any data
    '{16'h00B2, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},  // R4 back-to-back
    '{16'h00B3, 8'h00, 1'b0, 1'b1, 8'hF0, 1'b0, 1'b0}   // R3
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  rdA, rdB;
  logic        smiA, smiB, sciA, sciB;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  apm_smi_port #(.USE_SMI(1'b1)) u_apm_smi_port (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .ioRd(ioRd), .ioRdData(rdA), .smiReq(smiA), .sciEn(sciA)
  );

  apm_smi_port #(.USE_SMI(1'b0)) u_apm_smi_port_dec (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .ioRd(ioRd), .ioRdData(rdB), .smiReq(smiB), .sciEn(sciB)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    ioAddr = v.addr; ioWrData = v.data; ioWr = v.wr; ioRd = v.rd;
    #1;
    check(rdA == v.expRd, "R2 R3 R7 read smi-mode", rdA, v.expRd);
    check(rdB == v.expRd, "R2 R3 R7 read decode-mode", rdB, v.expRd);
    @(posedge clk);
    #1;
    check(smiA == v.expSmi, "R4 R5 smiReq smi-mode", smiA, v.expSmi);
    check(smiB == 1'b0, "R6 smiReq decode-mode", smiB, 0);
    check(sciB == v.expSci, "R6 R5 sciEn decode-mode", sciB, v.expSci);
    check(sciA == 1'b0, "R8 sciEn smi-mode", sciA, 0);
  endtask

  task automatic idle();
    @(negedge clk);
    ioWr = 1'b0; ioRd = 1'b0; ioAddr = '0; ioWrData = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: state during reset
    repeat (3) @(posedge clk);
    #1;
    check(smiA == 1'b0 && smiB == 1'b0, "R1 smiReq in reset", {smiA, smiB}, 0);
    check(sciA == 1'b0 && sciB == 1'b0, "R1 sciEn in reset", {sciA, sciB}, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: both bytes read zero after reset
    step('{16'h00B2, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0});
    step('{16'h00B3, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) step(VECS[i]);
    idle();
    @(posedge clk); #1;
    check(smiA == 1'b0, "R4 pulse ends after one cycle", smiA, 0);

    // R1: reset in mid-run clears everything
    step('{16'h00B2, 8'hF1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1});
    step('{16'h00B3, 8'h77, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1});
    idle();
    rstN = 1'b0;
    #1;
    check(sciB == 1'b0, "R1 sciEn cleared by reset", sciB, 0);
    check(smiA == 1'b0, "R1 smiReq cleared by reset", smiA, 0);
    @(negedge clk);
    rstN = 1'b1;
    step('{16'h00B2, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0});
    step('{16'h00B3, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0});
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule